// File: doc/BRIEF.md
# Packed BCD Add-with-Extend Unit

This block adds two packed BCD bytes (two decimal digits each) together with an incoming extend bit and returns the decimal sum along with updated condition flags. The extend bit acts as the carry-in. The zero flag can only be cleared, never set. Together these let software add decimal strings of any length one byte at a time: it presets zero to 1, clears extend, and feeds each new extend back in.

Register mode takes both operands from the `src_in` and `dst_in` ports and finishes in a single cycle. Memory mode runs a short sequence on a simple memory port with same-cycle read data:
- it predecrements the source pointer and reads the source byte;
- it predecrements the destination pointer and reads the destination byte;
- it adds the two bytes;
- it writes the sum back to the destination address and pulses `done`.

Top module: `bcdx_unit`

## Requirements
- R1: When `done` pulses, `result` equals `src + dst + x_in` computed in decimal on two packed digits (bits 7:4 are the tens digit, bits 3:0 the units digit).
- R2: Each digit is formed from its binary digit sum plus its carry-in. When that sum exceeds 9, 6 is added (modulo 16) and a carry goes to the next digit. Digit codes 10 to 15 go through the same rule and raise no error.
- R3: `c_out` is 1 exactly when the tens digit produced a decimal carry.
- R4: `x_out` always equals `c_out` after an operation.
- R5: `z_out` is 0 when the result byte is nonzero. When the result is zero it keeps the value of `z_in` given at start.
- R6: `n_out` and `v_out` take the values of `n_in` and `v_in` given at start, unchanged.
- R7: In register mode (`mem_mode`=0), a start seen while idle makes `done` high for exactly one cycle, right after the start edge, with `result` and the flags valid.
- R8: In memory mode (`mem_mode`=1), the cycles after the start edge run in this order:
  - cycle 1: a read at `src_ptr_in-1`;
  - cycle 2: a read at `dst_ptr_in-1`;
  - cycle 3: a cycle with no bus access;
  - cycle 4: a write of the sum to `dst_ptr_in-1`;
  - cycle 5: `done` high.
- R9: After a memory-mode operation, `src_ptr_out` and `dst_ptr_out` hold the decremented pointers. The decrement wraps modulo 2^AW.
- R10: `start` is ignored while `busy` is high, and `mem_rd` and `mem_wr` are never high together.
- R11: After reset, `done`, `mem_rd`, `mem_wr`, `busy`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mem_mode | input | 1 | 0: register operands, 1: memory operands |
| src_in | input | 8 | Source byte, register mode |
| dst_in | input | 8 | Destination byte, register mode |
| x_in | input | 1 | Extend flag in (decimal carry-in) |
| z_in | input | 1 | Zero flag in |
| n_in | input | 1 | Negative flag in |
| v_in | input | 1 | Overflow flag in |
| src_ptr_in | input | AW | Source pointer before predecrement |
| dst_ptr_in | input | AW | Destination pointer before predecrement |
| mem_rdata | input | 8 | Memory read data, valid in the cycle `mem_rd` is high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| result | output | 8 | Decimal sum byte |
| x_out | output | 1 | New extend flag |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New negative flag (held) |
| v_out | output | 1 | New overflow flag (held) |
| c_out | output | 1 | New carry flag |
| src_ptr_out | output | AW | Source pointer after the last memory operation |
| dst_ptr_out | output | AW | Destination pointer after the last memory operation |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong digit correction or carry chain shows up as a wrong `result` or `c_out` on the very `done` pulse of the operation concerned. It appears sooner on `mem_wdata`, in the write cycle of memory mode. A sequencer that enters the wrong state moves the read or write strobes, or their addresses, within one cycle of the start edge. A stale operand latch or pointer register appears in the following write address or in the pointer outputs at `done`. Zero-flag mistakes may stay hidden until a zero result arrives, so chains of zero and nonzero bytes are driven back to back.

// File: rtl/bcdx_pkg.sv
package bcdx_pkg;

  localparam int DIGIT_W = 4;
  localparam int DEC_MAX = 9;
  localparam int DEC_FIX = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_ADD,
    ST_WR
  } seq_state_t;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
  } flags_t;

  // One decimal digit step: returns {carry, digit}
  function automatic logic [DIGIT_W:0] digit_step(input logic [DIGIT_W-1:0] a,
                                                  input logic [DIGIT_W-1:0] b,
                                                  input logic cin);
    logic [DIGIT_W:0]   raw;
    logic               over;
    logic [DIGIT_W-1:0] fixed;
    raw   = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    over  = (raw > (DIGIT_W + 1)'(DEC_MAX));
    fixed = raw[DIGIT_W-1:0] + (over ? DIGIT_W'(DEC_FIX) : '0);
    return {over, fixed};
  endfunction

  // Flag update: extend mirrors carry, zero is sticky, N and V held
  function automatic flags_t flags_next(input flags_t old,
                                        input logic nonzero,
                                        input logic carry);
    flags_t f;
    f.x = carry;
    f.n = old.n;
    f.v = old.v;
    f.z = old.z & ~nonzero;
    return f;
  endfunction

endpackage

// File: rtl/bcdx_digit_cell.sv
module bcdx_digit_cell
  import bcdx_pkg::*;
(
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  input  logic               cin,
  output logic [DIGIT_W-1:0] sum,
  output logic               cout
);

  logic [DIGIT_W:0] step;

  assign step = digit_step(a, b, cin);
  assign sum  = step[DIGIT_W-1:0];
  assign cout = step[DIGIT_W];

endmodule

// File: rtl/bcdx_chain_adder.sv
module bcdx_chain_adder
  import bcdx_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [DIGITS*DIGIT_W-1:0] a,
  input  logic [DIGITS*DIGIT_W-1:0] b,
  input  logic                      cin,
  output logic [DIGITS*DIGIT_W-1:0] sum,
  output logic                      cout
);

  logic [DIGITS:0] cy;

  assign cy[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcdx_digit_cell u_cell (
      .a    (a[g*DIGIT_W +: DIGIT_W]),
      .b    (b[g*DIGIT_W +: DIGIT_W]),
      .cin  (cy[g]),
      .sum  (sum[g*DIGIT_W +: DIGIT_W]),
      .cout (cy[g+1])
    );
  end

  assign cout = cy[DIGITS];

endmodule

// File: rtl/bcdx_seq.sv
module bcdx_seq
  import bcdx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_mode,
  input  logic [AW-1:0] src_ptr_in,
  input  logic [AW-1:0] dst_ptr_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] src_ptr_q,
  output logic [AW-1:0] dst_ptr_q,
  output logic          load_mem,
  output logic          cap_src,
  output logic          cap_dst,
  output logic          add_mem,
  output logic          reg_fire,
  output logic          wr_fire,
  output logic          busy,
  output logic          done
);

  seq_state_t state_q, state_d;
  logic       accept;

  assign accept   = start && (state_q == ST_IDLE);
  assign reg_fire = accept && !mem_mode;
  assign load_mem = accept && mem_mode;
  assign cap_src  = (state_q == ST_RD_SRC);
  assign cap_dst  = (state_q == ST_RD_DST);
  assign add_mem  = (state_q == ST_ADD);
  assign wr_fire  = (state_q == ST_WR);
  assign busy     = (state_q != ST_IDLE);
  assign mem_rd   = cap_src || cap_dst;
  assign mem_wr   = wr_fire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load_mem) state_d = ST_RD_SRC;
      ST_RD_SRC: state_d = ST_RD_DST;
      ST_RD_DST: state_d = ST_ADD;
      ST_ADD:    state_d = ST_WR;
      ST_WR:     state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_RD_SRC: mem_addr = src_ptr_q - AW'(1);
      ST_RD_DST: mem_addr = dst_ptr_q - AW'(1);
      ST_WR:     mem_addr = dst_ptr_q;
      default:   mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      src_ptr_q <= '0;
      dst_ptr_q <= '0;
      done      <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= reg_fire || wr_fire;
      if (load_mem) begin
        src_ptr_q <= src_ptr_in;
        dst_ptr_q <= dst_ptr_in;
      end else begin
        if (cap_src) src_ptr_q <= src_ptr_q - AW'(1);
        if (cap_dst) dst_ptr_q <= dst_ptr_q - AW'(1);
      end
    end
  end

endmodule

// File: rtl/bcdx_unit.sv
module bcdx_unit
  import bcdx_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter int AW     = 8,
  localparam int W     = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_mode,
  input  logic [W-1:0]  src_in,
  input  logic [W-1:0]  dst_in,
  input  logic          x_in,
  input  logic          z_in,
  input  logic          n_in,
  input  logic          v_in,
  input  logic [AW-1:0] src_ptr_in,
  input  logic [AW-1:0] dst_ptr_in,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  result,
  output logic          x_out,
  output logic          z_out,
  output logic          n_out,
  output logic          v_out,
  output logic          c_out,
  output logic [AW-1:0] src_ptr_out,
  output logic [AW-1:0] dst_ptr_out,
  output logic          busy,
  output logic          done
);

  // Sequencer events, named for the checker and for readability
  logic load_mem, cap_src, cap_dst, add_mem, reg_fire, wr_fire, add_fire;

  bcdx_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_mode   (mem_mode),
    .src_ptr_in (src_ptr_in),
    .dst_ptr_in (dst_ptr_in),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .src_ptr_q  (src_ptr_out),
    .dst_ptr_q  (dst_ptr_out),
    .load_mem   (load_mem),
    .cap_src    (cap_src),
    .cap_dst    (cap_dst),
    .add_mem    (add_mem),
    .reg_fire   (reg_fire),
    .wr_fire    (wr_fire),
    .busy       (busy),
    .done       (done)
  );

  assign add_fire = reg_fire || add_mem;

  // Operand and flag latches used by the memory sequence
  logic [W-1:0] src_lat, dst_lat;
  flags_t       flags_lat, flags_in, flags_cur, flags_new, flags_q;

  assign flags_in = '{x: x_in, n: n_in, z: z_in, v: v_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_lat   <= '0;
      dst_lat   <= '0;
      flags_lat <= '0;
    end else begin
      if (load_mem) flags_lat <= flags_in;
      if (cap_src)  src_lat   <= mem_rdata;
      if (cap_dst)  dst_lat   <= mem_rdata;
    end
  end

  // Adder operand selection: latched values in the add state, ports otherwise
  logic [W-1:0] op_a, op_b, sum;
  logic         carry;

  assign op_a      = add_mem ? src_lat   : src_in;
  assign op_b      = add_mem ? dst_lat   : dst_in;
  assign flags_cur = add_mem ? flags_lat : flags_in;

  bcdx_chain_adder #(.DIGITS(DIGITS)) u_add (
    .a    (op_a),
    .b    (op_b),
    .cin  (flags_cur.x),
    .sum  (sum),
    .cout (carry)
  );

  assign flags_new = flags_next(flags_cur, |sum, carry);

  logic [W-1:0] result_q;
  logic         c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      c_q      <= 1'b0;
    end else if (add_fire) begin
      result_q <= sum;
      flags_q  <= flags_new;
      c_q      <= carry;
    end
  end

  assign result    = result_q;
  assign mem_wdata = result_q;
  assign x_out     = flags_q.x;
  assign z_out     = flags_q.z;
  assign n_out     = flags_q.n;
  assign v_out     = flags_q.v;
  assign c_out     = c_q;

endmodule

// File: rtl/bcdx_unit_chk.sv
module bcdx_unit_chk #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_mode,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] src_ptr_in,
  input logic [AW-1:0] dst_ptr_out,
  input logic [W-1:0]  result,
  input logic          x_out,
  input logic          c_out,
  input logic          z_out
);

  // R7
  reg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mem_mode) |=> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  x_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (x_out == c_out));

  // R5
  z_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result != '0)) |-> !z_out);

  // R8
  src_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mem_mode) |=> (mem_rd && (mem_addr == ($past(src_ptr_in) - AW'(1)))));

  // R8
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);

  // R9
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == dst_ptr_out));

  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind bcdx_unit bcdx_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mem_mode    (mem_mode),
  .busy        (busy),
  .done        (done),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .src_ptr_in  (src_ptr_in),
  .dst_ptr_out (dst_ptr_out),
  .result      (result),
  .x_out       (x_out),
  .c_out       (c_out),
  .z_out       (z_out)
);

// File: tb/bcdx_unit_test.sv
`timescale 1ns/1ps
module bcdx_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mem_mode = 1'b0;
  logic [7:0] src_in = '0, dst_in = '0;
  logic       x_in = 0, z_in = 0, n_in = 0, v_in = 0;
  logic [7:0] src_ptr_in = '0, dst_ptr_in = '0;
  logic [7:0] mem_rdata;
  logic       mem_rd, mem_wr;
  logic [7:0] mem_addr, mem_wdata, result;
  logic       x_out, z_out, n_out, v_out, c_out;
  logic [7:0] src_ptr_out, dst_ptr_out;
  logic       busy, done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bcdx_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_mode(mem_mode),
    .src_in(src_in), .dst_in(dst_in), .x_in(x_in), .z_in(z_in),
    .n_in(n_in), .v_in(v_in), .src_ptr_in(src_ptr_in), .dst_ptr_in(dst_ptr_in),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .result(result), .x_out(x_out), .z_out(z_out),
    .n_out(n_out), .v_out(v_out), .c_out(c_out), .src_ptr_out(src_ptr_out),
    .dst_ptr_out(dst_ptr_out), .busy(busy), .done(done)
  );

  // Memory model with same-cycle read and a preload path
  logic [7:0] mem [256];
  logic       pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    else if (pre_we) mem[pre_addr] <= pre_data;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: decimal digit-by-digit, restated with integers
  function automatic logic [8:0] ref_add(input logic [7:0] a, input logic [7:0] b, input logic x);
    int lo, hi;
    bit cl, ch;
    lo = int'(a[3:0]) + int'(b[3:0]) + int'(x);
    cl = (lo >= 10);
    if (cl) lo = (lo + 6) % 16;
    hi = int'(a[7:4]) + int'(b[7:4]) + int'(cl);
    ch = (hi >= 10);
    if (ch) hi = (hi + 6) % 16;
    return {ch, 4'(hi), 4'(lo)};
  endfunction

  function automatic logic [7:0] rand_bcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  task automatic preload(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = addr; pre_data = data;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic check_out(input logic [7:0] s, input logic [7:0] d,
                           input logic x, input logic z, input logic n, input logic v);
    logic [8:0] e;
    e = ref_add(s, d, x);
    check(done == 1'b1, "R7 done", int'(done), 1);
    check(result == e[7:0], "R1 R2 result", int'(result), int'(e[7:0]));
    check(c_out == e[8], "R3 carry", int'(c_out), int'(e[8]));
    check(x_out == e[8], "R4 extend", int'(x_out), int'(e[8]));
    check(z_out == (z && (e[7:0] == 8'h00)), "R5 zero", int'(z_out),
          int'(z && (e[7:0] == 8'h00)));
    check({n_out, v_out} == {n, v}, "R6 n/v", int'({n_out, v_out}), int'({n, v}));
  endtask

  task automatic do_reg(input logic [7:0] s, input logic [7:0] d,
                        input logic x, input logic z, input logic n, input logic v);
    @(negedge clk);
    src_in = s; dst_in = d; x_in = x; z_in = z; n_in = n; v_in = v;
    mem_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_out(s, d, x, z, n, v);
    @(negedge clk);
    check(done == 1'b0, "R7 pulse", int'(done), 0);
  endtask

  task automatic do_mem(input logic [7:0] sp, input logic [7:0] dp,
                        input logic [7:0] s, input logic [7:0] d,
                        input logic x, input logic z, input logic n, input logic v,
                        input bit poke);
    logic [8:0] e;
    e = ref_add(s, d, x);
    preload(sp - 8'd1, s);
    preload(dp - 8'd1, d);
    @(negedge clk);
    src_ptr_in = sp; dst_ptr_in = dp; x_in = x; z_in = z; n_in = n; v_in = v;
    mem_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    // R10: optionally keep start high with other operands while busy
    if (poke) begin
      mem_mode = 1'b0; src_in = 8'h77; dst_in = 8'h11; x_in = ~x; z_in = ~z;
      n_in = ~n; v_in = ~v; src_ptr_in = sp + 8'd9; dst_ptr_in = dp + 8'd9;
    end else start = 1'b0;
    check(mem_rd && !mem_wr && mem_addr == sp - 8'd1, "R8 src read", int'(mem_addr), int'(sp - 8'd1));
    @(negedge clk);
    check(mem_rd && !mem_wr && mem_addr == dp - 8'd1, "R8 dst read", int'(mem_addr), int'(dp - 8'd1));
    check(busy == 1'b1, "R10 busy", int'(busy), 1);
    start = 1'b0;
    @(negedge clk);
    check(!mem_rd && !mem_wr && !done, "R8 add cycle", int'({mem_rd, mem_wr, done}), 0);
    @(negedge clk);
    check(mem_wr && !mem_rd && mem_addr == dp - 8'd1 && mem_wdata == e[7:0], "R8 write",
          int'({mem_wr, mem_addr, mem_wdata}), int'({1'b1, dp - 8'd1, e[7:0]}));
    check(done == 1'b0, "R10 no early done", int'(done), 0);
    @(negedge clk);
    check_out(s, d, x, z, n, v);
    check(mem[dp - 8'd1] == e[7:0], "R8 stored", int'(mem[dp - 8'd1]), int'(e[7:0]));
    check(src_ptr_out == sp - 8'd1, "R9 src ptr", int'(src_ptr_out), int'(sp - 8'd1));
    check(dst_ptr_out == dp - 8'd1, "R9 dst ptr", int'(dst_ptr_out), int'(dp - 8'd1));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 R10 idle", int'({done, busy}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic xc, zc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check({done, mem_rd, mem_wr, busy} == 4'b0, "R11 strobes", int'({done, mem_rd, mem_wr, busy}), 0);
    check(result == 8'h00 && {x_out, z_out, n_out, v_out, c_out} == 5'b0, "R11 outputs",
          int'({result, x_out, z_out, n_out, v_out, c_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({done, busy, result} == '0, "R11 after release", int'({done, busy, result}), 0);

    // Directed corners
    do_reg(8'h99, 8'h99, 1'b1, 1'b1, 1'b0, 1'b0);   // R1 R3: 199 -> 99, carry
    do_reg(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);   // R5 zero keeps 1
    do_reg(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);   // R5 zero keeps 0
    do_reg(8'h50, 8'h50, 1'b0, 1'b1, 1'b1, 1'b1);   // R3 R5: 100 -> 00 carry, z kept
    do_reg(8'h09, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);   // R2 low-digit carry into tens
    do_reg(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0);   // R2 invalid digits -> 55, carry
    do_reg(8'hA0, 8'h0B, 1'b0, 1'b0, 1'b1, 1'b1);   // R2 invalid digits, no error

    // R5 chain: 0199 + 9801 = 10000, z must stay 1
    do_reg(8'h99, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    xc = x_out; zc = z_out;
    do_reg(8'h01, 8'h98, xc, zc, 1'b0, 1'b0);
    check(z_out == 1'b1 && c_out == 1'b1, "R5 chain zero", int'({z_out, c_out}), 3);
    // R5 chain: nonzero low byte clears z for the whole string
    do_reg(8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    xc = x_out; zc = z_out;
    do_reg(8'h00, 8'h00, xc, zc, 1'b0, 1'b0);
    check(z_out == 1'b0, "R5 chain sticky", int'(z_out), 0);

    // Memory mode corners, including pointer wrap (R9) and start while busy (R10)
    do_mem(8'h10, 8'h20, 8'h45, 8'h67, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    do_mem(8'h00, 8'h80, 8'h99, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_mem(8'h40, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_mem(8'h31, 8'h52, 8'h12, 8'h34, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    // Constrained random, register mode
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, b;
      a = (i % 5 == 4) ? 8'($urandom) : rand_bcd();
      b = (i % 7 == 6) ? 8'($urandom) : rand_bcd();
      do_reg(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Constrained random, memory mode
    for (int i = 0; i < 20; i++) begin
      logic [7:0] sp, dp;
      sp = 8'($urandom);
      dp = sp + 8'(1 + ($urandom % 200));
      do_mem(sp, dp, rand_bcd(), rand_bcd(), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), (i % 4 == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule